// File: doc/BRIEF.md
# Carry-save transposed FIR filter

This block is a programmable finite impulse response filter built in transposed form. A new signed sample enters every clock cycle and drives the multiplier of every tap at once. Each tap multiplies the sample by its own signed coefficient using radix-4 Booth recoding. A tree of 3:2 carry-save adders reduces the partial products to a sum and carry pair. A 4:2 compressor array then merges that pair with the redundant running sum handed down from the next tap. No tap resolves a carry. The only carry-propagate adder is a grouped carry-lookahead adder after the first tap register, and its result goes into the output register.

Coefficients are written one at a time through an address/data port with a write enable. The running sums are wide enough that no product or sum is ever rounded, truncated or overflowed, so the output is the exact convolution. A synchronous reset clears the coefficients, the tap chain and the output.

Top module: `fir_cs_transposed`

## Requirements
- R1: A clock edge with `rst` high clears all coefficients, all tap registers and `y_out` to zero. While the coefficients stay zero after reset, `y_out` stays zero for any input.
- R2: A write (`coef_we` high) stores `coef_data` into coefficient `coef_addr` at that edge. The product formed at the same edge still uses the old value, and the new value applies from the next edge on.
- R3: While `coef_we` is low, no coefficient changes, whatever `coef_addr` and `coef_data` carry.
- R4: Every tap product is the exact signed product of two 10-bit two's-complement values, including the extreme case (-512)·(-512) = 262144 and the case 511·(-512).
- R5: After clock edge e, `y_out` holds, as an AW-bit two's-complement value (AW = 10 + 10 + log2 N = 23 by default), the sum over k = 0..N-1 of c_k·x(e-1-k). Here x(j) is the sample presented at edge j and c_k is tap k's coefficient as it stood at edge e-1-k. A new sample is accepted every cycle.
- R6: A single nonzero sample v presented at edge t, with zeros before and after, gives `y_out` = c_k·v after edge t+1+k for k = 0..N-1, and zero from edge t+N+1 on.
- R7: The result is exact at full scale: N taps of coefficient -512 fed a constant -512 give N·262144 (2097152 for N = 8) with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | XW (10) | Signed input sample, one per cycle |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | log2 N (3) | Index of the tap whose coefficient is written |
| coef_data | input | CW (10) | Signed coefficient value |
| y_out | output | AW (23) | Exact signed filter output, registered |

## Verification
A coefficient write and the product formed with that same coefficient can fall in the same cycle. The bench provokes this by writing a tap while nonzero samples stream in, both in a directed pair of cycles and in a random phase where writes arrive on most cycles. The reference model records each product with the coefficient as it stood before the edge, then applies the write. A mismatch in either order shows up in `y_out` as soon as that product reaches the first tap.

// File: rtl/fir_cs_pkg.sv
package fir_cs_pkg;

    // Radix-4 Booth digit: value = (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

    // Window is {b[2i+1], b[2i], b[2i-1]}
    function automatic booth_dig_t booth_decode(input logic [2:0] w);
        booth_dig_t d;
        d.one = w[1] ^ w[0];
        d.two = (w[2] & ~w[1] & ~w[0]) | (~w[2] & w[1] & w[0]);
        d.neg = w[2] & ~(w[1] & w[0]);
        return d;
    endfunction

endpackage

// File: rtl/booth_cs_mult.sv
module booth_cs_mult #(
    parameter int XW = 10,
    parameter int CW = 10,
    parameter int AW = 23
) (
    input  logic [XW-1:0] x,
    input  logic [CW-1:0] c,
    output logic [AW-1:0] ps,
    output logic [AW-1:0] pc
);
    import fir_cs_pkg::*;

    localparam int NPP = (CW + 1) / 2;
    localparam int CXW = 2 * NPP + 1;
    localparam int OPS = NPP + 1;

    logic [AW-1:0]  xe;
    logic [CXW-2:0] c_ext;
    logic [CXW-1:0] cx;

    assign xe    = AW'($signed(x));
    assign c_ext = (CXW - 1)'($signed(c));
    assign cx    = {c_ext, 1'b0};

    always_comb begin
        logic [AW-1:0] cur [OPS];
        logic [AW-1:0] nxt [OPS];
        logic [AW-1:0] mag;
        logic [AW-1:0] corr;
        booth_dig_t    dig;
        int            cnt;
        int            n;

        corr = '0;
        for (int i = 0; i < NPP; i++) begin
            dig = booth_decode(cx[2*i +: 3]);
            mag = dig.two ? (xe << 1) : (dig.one ? xe : '0);
            // invert before the shift; the +1 of the negation goes to bit 2i
            cur[i] = (dig.neg ? ~mag : mag) << (2 * i);
            corr[2*i] = dig.neg;
        end
        cur[OPS-1] = corr;

        // Level-wise 3:2 reduction until two rows remain
        cnt = OPS;
        n   = 0;
        for (int lvl = 0; lvl < OPS; lvl++) begin
            for (int i = 0; i < OPS; i++) nxt[i] = '0;
            if (cnt > 2) begin
                n = 0;
                for (int g = 0; g < OPS / 3; g++) begin
                    if (3 * g + 2 < cnt) begin
                        nxt[n]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
                        nxt[n+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2])
                                   | (cur[3*g+1] & cur[3*g+2])) << 1;
                        n = n + 2;
                    end
                end
                for (int i = 0; i < OPS; i++) begin
                    if (i >= 3 * (cnt / 3) && i < cnt) begin
                        nxt[n] = cur[i];
                        n = n + 1;
                    end
                end
                cur = nxt;
                cnt = n;
            end
        end
        ps = cur[0];
        pc = cur[1];
    end

endmodule

// File: rtl/csa42.sv
module csa42 #(
    parameter int W = 23
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] s1;
    logic [W-1:0] c1;

    assign s1 = a ^ b ^ c;
    assign c1 = ((a & b) | (a & c) | (b & c)) << 1;
    assign s  = s1 ^ c1 ^ d;
    assign cy = ((s1 & c1) | (s1 & d) | (c1 & d)) << 1;

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int W = 23
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int NG = (W + 3) / 4;

    logic [W-1:0] g;
    logic [W-1:0] p;

    assign g = a & b;
    assign p = a ^ b;

    // 4-bit lookahead groups, group carries chained
    always_comb begin
        logic [W-1:0] cc;
        cc = '0;
        for (int j = 0; j < NG; j++) begin
            for (int b4 = 0; b4 < 4; b4++) begin
                logic t;
                logic run;
                t   = 1'b0;
                run = 1'b1;
                if (4 * j + b4 < W - 1) begin
                    for (int k = b4; k >= 0; k--) begin
                        t   = t | (run & g[4*j+k]);
                        run = run & p[4*j+k];
                    end
                    cc[4*j+b4+1] = t | (run & cc[4*j]);
                end
            end
        end
        sum = p ^ cc;
    end

endmodule

// File: rtl/fir_cs_transposed.sv
module fir_cs_transposed #(
    parameter int N_TAPS = 8,
    parameter int XW     = 10,
    parameter int CW     = 10,
    localparam int AW    = XW + CW + $clog2(N_TAPS),
    localparam int AD    = (N_TAPS > 1) ? $clog2(N_TAPS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x_in,
    input  logic          coef_we,
    input  logic [AD-1:0] coef_addr,
    input  logic [CW-1:0] coef_data,
    output logic [AW-1:0] y_out
);

    typedef struct packed {
        logic [N_TAPS-1:0][CW-1:0] coef;
        logic [N_TAPS-1:0][AW-1:0] ts;
        logic [N_TAPS-1:0][AW-1:0] tc;
        logic [AW-1:0]             y;
    } fir_state_t;

    fir_state_t st_d, st_q;

    logic [AW-1:0] prod_s [N_TAPS];
    logic [AW-1:0] prod_c [N_TAPS];
    logic [AW-1:0] up_s   [N_TAPS];
    logic [AW-1:0] up_c   [N_TAPS];
    logic [AW-1:0] sum_s  [N_TAPS];
    logic [AW-1:0] sum_c  [N_TAPS];
    logic [AW-1:0] cpa_sum;

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        booth_cs_mult #(.XW(XW), .CW(CW), .AW(AW)) u_mul (
            .x  (x_in),
            .c  (st_q.coef[i]),
            .ps (prod_s[i]),
            .pc (prod_c[i])
        );
        if (i == N_TAPS - 1) begin : g_last
            assign up_s[i] = '0;
            assign up_c[i] = '0;
        end else begin : g_mid
            assign up_s[i] = st_q.ts[i+1];
            assign up_c[i] = st_q.tc[i+1];
        end
        csa42 #(.W(AW)) u_cmp (
            .a  (prod_s[i]),
            .b  (prod_c[i]),
            .c  (up_s[i]),
            .d  (up_c[i]),
            .s  (sum_s[i]),
            .cy (sum_c[i])
        );
    end

    cla_adder #(.W(AW)) u_cpa (
        .a   (st_q.ts[0]),
        .b   (st_q.tc[0]),
        .sum (cpa_sum)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < N_TAPS; i++) begin
                st_d.ts[i] = sum_s[i];
                st_d.tc[i] = sum_c[i];
            end
            st_d.y = cpa_sum;
            if (coef_we && int'(coef_addr) < N_TAPS) begin
                st_d.coef[coef_addr] = coef_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y_out = st_q.y;

endmodule

// File: rtl/fir_cs_chk.sv
module fir_cs_chk #(
    parameter int N_TAPS = 8,
    parameter int XW     = 10,
    parameter int CW     = 10,
    localparam int AW    = XW + CW + $clog2(N_TAPS),
    localparam int AD    = (N_TAPS > 1) ? $clog2(N_TAPS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [XW-1:0]        x_in,
    input logic                 coef_we,
    input logic [AD-1:0]        coef_addr,
    input logic [CW-1:0]        coef_data,
    input logic [AW-1:0]        y_out,
    input logic [N_TAPS*CW-1:0] coef_flat,
    input logic [AW-1:0]        head_s,
    input logic [AW-1:0]        head_c,
    input logic [AW-1:0]        tail_s,
    input logic [AW-1:0]        tail_c
);
    logic seen_rst = 1'b0;
    logic armed    = 1'b0;

    always_ff @(posedge clk) begin
        seen_rst <= seen_rst | rst;
        armed    <= seen_rst;
    end

    logic [AW-1:0] head_sum;
    logic [AW-1:0] tail_sum;
    logic [AW-1:0] tail_ref;
    logic [CW-1:0] tail_coef;

    assign head_sum  = head_s + head_c;
    assign tail_sum  = tail_s + tail_c;
    assign tail_coef = coef_flat[(N_TAPS-1)*CW +: CW];
    assign tail_ref  = AW'($signed(tail_coef)) * AW'($signed(x_in));

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (y_out == '0 && coef_flat == '0 && head_s == '0 && head_c == '0));

    // R3
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !coef_we) |=> $stable(coef_flat));

    // R2
    coef_write_chk: assert property (@(posedge clk) disable iff (rst)
        (coef_we && int'(coef_addr) < N_TAPS)
        |=> coef_flat[$past(coef_addr)*CW +: CW] == $past(coef_data));

    // R4
    tail_product_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst)) |-> tail_sum == $past(tail_ref));

    // R5
    final_adder_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst)) |-> y_out == $past(head_sum));

endmodule

bind fir_cs_transposed fir_cs_chk #(.N_TAPS(N_TAPS), .XW(XW), .CW(CW)) u_fir_cs_chk (
    .clk       (clk),
    .rst       (rst),
    .x_in      (x_in),
    .coef_we   (coef_we),
    .coef_addr (coef_addr),
    .coef_data (coef_data),
    .y_out     (y_out),
    .coef_flat (st_q.coef),
    .head_s    (st_q.ts[0]),
    .head_c    (st_q.tc[0]),
    .tail_s    (st_q.ts[N_TAPS-1]),
    .tail_c    (st_q.tc[N_TAPS-1])
);

// File: tb/test_fir_cs_transposed.sv
module test_fir_cs_transposed;
    localparam int N  = 8;
    localparam int XW = 10;
    localparam int CW = 10;
    localparam int AW = XW + CW + $clog2(N);
    localparam int AD = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [XW-1:0] x_in = '0;
    logic          coef_we = 1'b0;
    logic [AD-1:0] coef_addr = '0;
    logic [CW-1:0] coef_data = '0;
    logic [AW-1:0] y_out;

    always #10 clk = ~clk;

    fir_cs_transposed #(.N_TAPS(N), .XW(XW), .CW(CW)) i_fir_cs_transposed (
        .clk       (clk),
        .rst       (rst),
        .x_in      (x_in),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .y_out     (y_out)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint coef_m [N];
    longint hist [N+1][N];

    function automatic longint sx(input logic [XW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint sc(input logic [CW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [AW-1:0] model_y();
        longint s = 0;
        for (int k = 0; k < N; k++) s += hist[k+1][k];
        return AW'(s);
    endfunction

    task automatic clear_model();
        for (int k = 0; k < N; k++) coef_m[k] = 0;
        for (int d = 0; d <= N; d++)
            for (int k = 0; k < N; k++) hist[d][k] = 0;
    endtask

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_chk++;
        if (y_out !== exp) begin
            n_bad++;
            $display("FAIL %s: y_out=%0d expected=%0d", req, $signed(y_out), $signed(exp));
        end
    endtask

    // one cycle: drive at negedge, model the edge, check at the next negedge
    task automatic step(input string req, input logic [XW-1:0] x, input logic we,
                        input int addr, input logic [CW-1:0] d);
        x_in = x; coef_we = we; coef_addr = AD'(addr); coef_data = d;
        @(posedge clk);
        for (int dd = N; dd > 0; dd--) hist[dd] = hist[dd-1];
        for (int k = 0; k < N; k++) hist[0][k] = coef_m[k] * sx(x);
        if (we) coef_m[addr] = sc(d);
        @(negedge clk);
        check(req, model_y());
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_model();
        @(negedge clk);
        x_in = 10'sd77; coef_we = 1'b1; coef_data = 10'sd5;
        repeat (4) @(negedge clk);
        rst = 1'b0; coef_we = 1'b0; x_in = '0;
        // R1: output cleared by reset
        check("R1", '0);
        // R1: coefficients cleared, input has no effect
        for (int i = 0; i < 4; i++) step("R1", 10'sd300, 1'b0, 0, '0);

        // load coefficients: k*37 - 130, alternating sign pattern
        for (int k = 0; k < N; k++)
            step("R2", '0, 1'b1, k, CW'(((k % 2) ? -1 : 1) * (k * 37 - 130)));
        for (int i = 0; i < N + 1; i++) step("R5", '0, 1'b0, 0, '0);

        // R6: impulse response, then silence
        step("R6", 10'sd5, 1'b0, 0, '0);
        for (int i = 0; i < N + 2; i++) step("R6", '0, 1'b0, 0, '0);
        step("R6", -10'sd3, 1'b0, 0, '0);
        for (int i = 0; i < N + 2; i++) step("R6", '0, 1'b0, 0, '0);

        // R2: write tap 0 on the same edge a sample arrives
        step("R2", 10'sd1, 1'b1, 0, 10'sd100);
        step("R2", 10'sd1, 1'b0, 0, '0);
        step("R2", 10'sd1, 1'b1, 0, -10'sd200);
        for (int i = 0; i < N + 1; i++) step("R2", '0, 1'b0, 0, '0);

        // R4 / R7: extreme products
        for (int k = 0; k < N; k++) step("R4", '0, 1'b1, k, 10'h200);
        for (int i = 0; i < N + 2; i++) step("R7", 10'h200, 1'b0, 0, '0);
        n_chk++;
        if (y_out !== AW'(longint'(N) * 262144)) begin
            n_bad++;
            $display("FAIL R7: y_out=%0d expected=%0d", $signed(y_out), N * 262144);
        end
        step("R4", '0, 1'b1, N - 1, 10'sd511);
        for (int i = 0; i < N + 2; i++) step("R4", 10'h200, 1'b0, 0, '0);
        step("R4", 10'sd511, 1'b0, 0, '0);
        for (int i = 0; i < N + 1; i++) step("R4", '0, 1'b0, 0, '0);

        // R3: write enable low while address and data toggle
        for (int i = 0; i < 60; i++)
            step("R3", XW'($urandom()), 1'b0, int'($urandom() % N), CW'($urandom()));

        // R2: random writes on most cycles during a random stream
        for (int i = 0; i < 200; i++)
            step("R2", XW'($urandom()), ($urandom() % 4) != 0, int'($urandom() % N), CW'($urandom()));

        // R5: random stream with rare writes
        for (int i = 0; i < 300; i++)
            step("R5", XW'($urandom()), ($urandom() % 16) == 0, int'($urandom() % N), CW'($urandom()));

        // R1: reset in mid-stream clears everything again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        clear_model();
        check("R1", '0);
        for (int i = 0; i < 3; i++) step("R1", 10'sd123, 1'b0, 0, '0);

        summary();
        $finish;
    end

endmodule